// File: doc/BRIEF.md
# Decade Johnson Counter with One-Hot Decode

This block counts clock edges modulo ten. The count is held in a five-stage twisted-ring shift register: each step shifts the register left and feeds the inverse of its top stage back into its bottom stage. That register has ten legal patterns. Each pattern is turned into one line of a one-hot phase bus, using only two adjacent ring bits per line. Both the phase bus and a carry line are registered.

The carry line is a square wave at one tenth of the counted rate. It is high for the first half of the cycle and rises on the wrap from the last phase back to phase 0. To build a longer chain, feed the carry of one stage into the clock of the next stage, or gate the next stage with the inhibit input.

A synchronous reset puts the counter in phase 0. An inhibit input freezes the count. If the ring ever holds a pattern outside the legal ten, for example after an upset, the next-state logic forces it back to phase 0 on the following edge.

Top module: `decade_johnson`

## Requirements
- R1: On a rising edge with `rst` high, `phase_o` becomes 1 in bit 0 only and `carry_o` becomes 1, whatever the value of `inhibit`.
- R2: After the first reset edge, `phase_o` has exactly one bit set on every cycle.
- R3: Bit k of `phase_o` high means count k. On a rising edge with `rst` and `inhibit` low, the set bit moves from index k to index k+1.
- R4: The count wraps from the last index (2*STAGES-1, which is 9 by default) back to index 0, so one full cycle takes 2*STAGES counted edges.
- R5: `carry_o` is high while the active index is in 0..STAGES-1 and low while it is in STAGES..2*STAGES-1.
- R6: `carry_o` rises only on the edge where the active index goes from the last index to 0.
- R7: On a rising edge with `inhibit` high and `rst` low, `phase_o` and `carry_o` keep their values.
- R8: If the ring register holds a pattern that is not one of the 2*STAGES legal codes, the next rising edge loads phase 0 (`phase_o` bit 0 set, `carry_o` high), whatever the value of `inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter acts on rising edges |
| rst | input | 1 | Synchronous active-high reset to phase 0 |
| inhibit | input | 1 | Active-high count freeze |
| phase_o | output | 2*STAGES | Registered one-hot phase; bit k set means count k |
| carry_o | output | 1 | Registered carry, a square wave at 1/(2*STAGES) of the counted rate |

## Verification
The bench builds the block with the default of five stages, which gives a ten-phase cycle. At that size the bench can run several complete wraps, so the wrap edge and the rising carry come up again and again within a short run. Inhibit runs and a reset in the middle of a count are placed at different phases. Two illegal ring patterns are forced into the register, one with inhibit low and one with inhibit high, to reach the repair path, which no port can produce.

// File: rtl/decade_pkg.sv
package decade_pkg;
  parameter int DEF_STAGES = 5;

  typedef enum logic [1:0] {
    ACT_RESET  = 2'd0,
    ACT_REPAIR = 2'd1,
    ACT_HOLD   = 2'd2,
    ACT_STEP   = 2'd3
  } ring_act_e;
endpackage

// File: rtl/jc_legal.sv
module jc_legal #(
  parameter int STAGES = decade_pkg::DEF_STAGES
) (
  input  logic [STAGES-1:0] code_i,
  output logic              legal_o
);
  localparam int NEDGE = STAGES - 1;

  logic [NEDGE-1:0] boundary;

  // A legal twisted-ring code has at most one place where neighbours differ.
  for (genvar i = 0; i < NEDGE; i++) begin : g_bound
    assign boundary[i] = code_i[i] ^ code_i[i+1];
  end

  assign legal_o = ($countones(boundary) <= 1);
endmodule

// File: rtl/jc_decode.sv
module jc_decode #(
  parameter int STAGES = decade_pkg::DEF_STAGES
) (
  input  logic [STAGES-1:0]   code_i,
  output logic [2*STAGES-1:0] onehot_o
);
  localparam int NSTATES = 2 * STAGES;

  // Each phase is recognised from one pair of ring bits.
  for (genvar k = 0; k < NSTATES; k++) begin : g_phase
    if (k == 0) begin : g_empty
      assign onehot_o[k] = ~code_i[0] & ~code_i[STAGES-1];
    end else if (k < STAGES) begin : g_filling
      assign onehot_o[k] = code_i[k-1] & ~code_i[k];
    end else if (k == STAGES) begin : g_full
      assign onehot_o[k] = code_i[0] & code_i[STAGES-1];
    end else begin : g_draining
      assign onehot_o[k] = ~code_i[k-STAGES-1] & code_i[k-STAGES];
    end
  end
endmodule

// File: rtl/jc_ring.sv
module jc_ring
  import decade_pkg::*;
#(
  parameter int STAGES = DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inhibit,
  output logic [STAGES-1:0] state_d,
  output logic              legal_o
);
  logic [STAGES-1:0] state_q;
  ring_act_e         act;

  jc_legal #(.STAGES(STAGES)) u_legal (
    .code_i  (state_q),
    .legal_o (legal_o)
  );

  // Priority: reset, then repair of an illegal code, then inhibit, then step.
  always_comb begin
    if (rst)           act = ACT_RESET;
    else if (!legal_o) act = ACT_REPAIR;
    else if (inhibit)  act = ACT_HOLD;
    else               act = ACT_STEP;
  end

  always_comb begin
    case (act)
      ACT_RESET,
      ACT_REPAIR: state_d = '0;
      ACT_HOLD:   state_d = state_q;
      default:    state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
    endcase
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end
endmodule

// File: rtl/decade_johnson.sv
module decade_johnson #(
  parameter int STAGES = decade_pkg::DEF_STAGES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inhibit,
  output logic [2*STAGES-1:0] phase_o,
  output logic                carry_o
);
  localparam int NSTATES = 2 * STAGES;

  logic [STAGES-1:0]  ring_d;
  logic               ring_ok;
  logic [NSTATES-1:0] phase_d;

  jc_ring #(.STAGES(STAGES)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .inhibit (inhibit),
    .state_d (ring_d),
    .legal_o (ring_ok)
  );

  // Decode the next ring value so the registered outputs line up with the ring.
  jc_decode #(.STAGES(STAGES)) u_dec (
    .code_i   (ring_d),
    .onehot_o (phase_d)
  );

  always_ff @(posedge clk) begin
    phase_o <= phase_d;
    carry_o <= ~ring_d[STAGES-1];
  end
endmodule

// File: rtl/decade_johnson_chk.sv
module decade_johnson_chk #(
  parameter int STAGES = decade_pkg::DEF_STAGES
) (
  input logic                clk,
  input logic                rst,
  input logic                inhibit,
  input logic [2*STAGES-1:0] phase_o,
  input logic                carry_o,
  input logic                ring_ok
);
  localparam int NSTATES = 2 * STAGES;
  localparam logic [NSTATES-1:0] PH0 = NSTATES'(1);

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (phase_o == PH0) && carry_o);

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    $countones(phase_o) == 1);

  p_step_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    (!inhibit && ring_ok) |=>
      phase_o == {$past(phase_o[NSTATES-2:0]), $past(phase_o[NSTATES-1])});

  p_carry_level_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    carry_o == (|phase_o[STAGES-1:0]));

  p_carry_rise_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(carry_o) |-> phase_o[0]);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    (inhibit && ring_ok) |=> $stable(phase_o) && $stable(carry_o));

  p_repair_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    !ring_ok |=> ring_ok && (phase_o == PH0) && carry_o);
endmodule

bind decade_johnson decade_johnson_chk #(.STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inhibit (inhibit),
  .phase_o (phase_o),
  .carry_o (carry_o),
  .ring_ok (ring_ok)
);

// File: tb/decade_johnson_tb_top.sv
`timescale 1ns/100ps
module decade_johnson_tb_top;
  localparam int STAGES  = 5;
  localparam int NSTATES = 2 * STAGES;

  typedef struct {
    logic [NSTATES-1:0] ph;
    logic               cy;
    string              tag;
    int                 due;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inhibit = 1'b0;
  logic [NSTATES-1:0] phase_o;
  logic carry_o;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  int   idx = 0;
  logic prev_cy = 1'b0;
  bit   finished = 1'b0;
  exp_t sb[$];

  decade_johnson #(.STAGES(STAGES)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .inhibit (inhibit),
    .phase_o (phase_o),
    .carry_o (carry_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [NSTATES-1:0] act,
                     input logic [NSTATES-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input string tag);
    exp_t it;
    it.ph  = NSTATES'(1) << idx;
    it.cy  = (idx < STAGES);
    it.tag = tag;
    it.due = cyc + 1;
    sb.push_back(it);
  endtask

  // Driver: inputs change 1 ns after a rising edge, expectation due at the next edge.
  task automatic step(input logic r, input logic inh);
    string tag;
    rst = r;
    inhibit = inh;
    if (r) begin
      idx = 0; tag = "R1";
    end else if (inh) begin
      tag = "R7";
    end else begin
      idx = (idx + 1) % NSTATES;
      tag = (idx == 0) ? "R4" : "R3";
    end
    push(tag);
    @(posedge clk); #1;
  endtask

  task automatic repair(input logic [STAGES-1:0] pat, input logic inh);
    force dut_i.u_ring.state_q = pat;
    #0.2;
    release dut_i.u_ring.state_q;
    rst = 1'b0;
    inhibit = inh;
    idx = 0;
    push("R8");
    @(posedge clk); #1;
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t it;
      it = sb.pop_front();
      chk(phase_o == it.ph, it.tag, phase_o, it.ph);
      chk($countones(phase_o) == 1, "R2", phase_o, it.ph);
      chk(carry_o == it.cy, (it.cy && !prev_cy) ? "R6" : "R5",
          NSTATES'(carry_o), NSTATES'(it.cy));
      prev_cy = it.cy;
    end
  end

  initial begin
    #1;
    step(1'b1, 1'b1);                          // R1: reset beats inhibit
    step(1'b1, 1'b0);
    for (int i = 0; i < 25; i++) step(1'b0, 1'b0);   // R3/R4: wraps
    for (int i = 0; i < 3; i++)  step(1'b0, 1'b1);   // R7: hold
    for (int i = 0; i < 4; i++)  step(1'b0, 1'b0);
    for (int i = 0; i < 8; i++)  step(1'b0, logic'(i % 2));
    step(1'b1, 1'b1);                          // R1: mid-count reset
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
    repair(5'b01010, 1'b0);                    // R8
    for (int i = 0; i < 3; i++)  step(1'b0, 1'b0);
    repair(5'b11011, 1'b1);                    // R8 with inhibit high
    for (int i = 0; i < 2; i++)  step(1'b0, 1'b1);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule